// File: doc/BRIEF.md
# Codec Serial Control Port Writer

This block is a master for a three-wire serial control port that is shared by two codec chips. The port has one data line, one clock line and one active-low select per chip. A host hands over a chip index, a 5-bit register address and a data byte. The block then shifts out a 16-bit write frame to the addressed chip. Every phase of the bit timing lasts `cfg_phase + 1` system clocks.

Two helper requests sit beside the plain write. A sample-rate request turns the rate in hertz into a 4-bit speed mode. It then rewrites the format register (address 0x02) in chip 0 and then in chip 1. A mute request sets or clears the soft-mute bit of register 0x03 in both chips. Both helpers are read-modify-writes. They work from per-chip shadow copies of those two registers, and ordinary writes to those addresses keep the shadows up to date.

All three request kinds share one `ready` signal, which is high only while the block is idle.

Top module: `codec_ctl_writer`

## Requirements
- R1: A write to chip c, register a, data d sends the frame {2'b10, 1'b1, a[4:0], d[7:0]} MSB first. It uses exactly 16 rising clock edges while the select is low, and the codec captures each bit on the rising edge.
- R2: During a frame only the select of the addressed chip (cs_n[0] for chip 0, cs_n[1] for chip 1) is low. The two selects are never low together.
- R3: When idle, data, clock and both selects are high. They return high after each frame. `busy` is high, and `ready` is low, from acceptance until the last frame ends.
- R4: For each bit the clock falls first. The data line then changes while the clock is low, and the clock then rises. Data is stable while the clock is high inside a frame.
- R5: Every phase lasts cfg_phase+1 system clocks. Within a frame the clock is low for 2*(cfg_phase+1) clocks per bit and high for cfg_phase+1 clocks between bits.
- R6: A write whose chip index is 2 or 3 produces a one-cycle `err` pulse in the cycle after acceptance. Nothing toggles on the serial port and `busy` stays low.
- R7: A rate request replaces bits 3:0 of register 0x02 and keeps bits 7:4 from the shadow. The new bits are 4'b1010 for a rate above 108000 Hz, 4'b0101 for a rate above 54000 Hz up to 108000 Hz, and 4'b0000 otherwise. Chip 0 is written first, then chip 1.
- R8: A rate request with value 0 is accepted and sends nothing.
- R9: A mute request writes bit 7 of register 0x03 (1 = muted) and keeps bits 6:0 from the shadow. Chip 0 is written first, then chip 1.
- R10: The shadows for registers 0x02 and 0x03 reset to 0. Any write to those addresses, direct or by a helper, updates the shadow of that chip.
- R11: When several requests are valid in one idle cycle, all are consumed. Only the highest one acts, in the order write, then rate, then mute.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_phase | input | DIV_W | Phase length minus one, in system clocks |
| wr_valid | input | 1 | Direct register write request |
| wr_chip | input | 2 | Target chip index (0 or 1 valid) |
| wr_addr | input | 5 | Register address |
| wr_data | input | 8 | Register data |
| rate_valid | input | 1 | Sample-rate update request |
| rate_hz | input | RATE_W | New sample rate in Hz, 0 = unknown |
| mute_valid | input | 1 | Soft-mute update request |
| mute_on | input | 1 | 1 mutes, 0 unmutes |
| ready | output | 1 | Requests are consumed in this cycle |
| busy | output | 1 | A frame sequence is in progress |
| err | output | 1 | One-cycle pulse for a bad chip index |
| cs_n | output | 2 | Active-low chip selects |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data |

## Verification
The embedded assertions check the following on every cycle:
- the two selects are never low together;
- the idle lines are all high whenever the block is ready;
- `busy` covers every cycle in which a select is low;
- data is stable across each clock-high interval inside a frame;
- an error pulse follows only a rejected chip index and leaves the port quiet.

Only the bench scenarios show the following:
- the frame contents, which are captured by a receiver model on each rising clock edge;
- the rate-to-mode thresholds at exactly 54000 and 108000 Hz;
- that the upper shadow bits survive the read-modify-write;
- the chip ordering of the helpers, request priority and the measured phase lengths.

// File: rtl/codec_ctl_writer.sv
`timescale 1ns/1ps
module codec_ctl_writer #(
  parameter int DIV_W  = 8,
  parameter int RATE_W = 18,
  parameter int HI_HZ  = 108000,
  parameter int MID_HZ = 54000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_phase,
  input  logic              wr_valid,
  input  logic [1:0]        wr_chip,
  input  logic [4:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rate_valid,
  input  logic [RATE_W-1:0] rate_hz,
  input  logic              mute_valid,
  input  logic              mute_on,
  output logic              ready,
  output logic              busy,
  output logic              err,
  output logic [1:0]        cs_n,
  output logic              sck,
  output logic              sdo
);
  localparam logic [1:0] DEV_ID  = 2'b10;
  localparam logic [4:0] FMT_REG = 5'h02;
  localparam logic [4:0] VOL_REG = 5'h03;
  localparam int         FRAME_W = 16;
  localparam int         BIT_W   = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  typedef enum logic [2:0] {S_IDLE, S_SEL, S_LOW, S_DAT, S_HIGH, S_REL} st_t;
  typedef enum logic [1:0] {J_WR, J_RATE, J_MUTE} job_t;

  st_t                st;
  job_t               job;
  logic [DIV_W-1:0]   cnt;
  logic [BIT_W-1:0]   bitn;
  logic [FRAME_W-1:0] sh;
  logic               chip;
  logic [3:0]         mode;
  logic               mute_q;
  logic [7:0]         fmt_sh [2];
  logic [7:0]         vol_sh [2];
  logic [1:0]         cs_q;
  logic               sck_q, sdo_q, err_q;

  function automatic logic [3:0] rate_mode(input logic [RATE_W-1:0] r);
    if (r > RATE_W'(HI_HZ))       return 4'b1010;
    else if (r > RATE_W'(MID_HZ)) return 4'b0101;
    else                          return 4'b0000;
  endfunction

  logic       done;
  logic       go, go_chip, bad;
  logic [4:0] go_addr;
  logic [7:0] go_data;
  job_t       go_job;
  logic [3:0] m_in;

  assign done  = (cnt == '0);
  assign ready = (st == S_IDLE);
  assign busy  = !ready;
  assign err   = err_q;
  assign cs_n  = cs_q;
  assign sck   = sck_q;
  assign sdo   = sdo_q;
  assign m_in  = rate_mode(rate_hz);
  assign bad   = ready && wr_valid && (wr_chip > 2'd1);

  always_comb begin
    go      = 1'b0;
    go_chip = 1'b0;
    go_addr = '0;
    go_data = '0;
    go_job  = J_WR;
    if (ready) begin
      if (wr_valid) begin
        go      = !bad;
        go_chip = wr_chip[0];
        go_addr = wr_addr;
        go_data = wr_data;
      end else if (rate_valid && rate_hz != '0) begin
        go      = 1'b1;
        go_job  = J_RATE;
        go_addr = FMT_REG;
        go_data = {fmt_sh[0][7:4], m_in};
      end else if (mute_valid) begin
        go      = 1'b1;
        go_job  = J_MUTE;
        go_addr = VOL_REG;
        go_data = {mute_on, vol_sh[0][6:0]};
      end
    end else if (st == S_REL && done && job != J_WR && !chip) begin
      go      = 1'b1;
      go_chip = 1'b1;
      go_job  = job;
      if (job == J_RATE) begin
        go_addr = FMT_REG;
        go_data = {fmt_sh[1][7:4], mode};
      end else begin
        go_addr = VOL_REG;
        go_data = {mute_q, vol_sh[1][6:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      job    <= J_WR;
      cnt    <= '0;
      bitn   <= '0;
      sh     <= '0;
      chip   <= 1'b0;
      mode   <= '0;
      mute_q <= 1'b0;
      fmt_sh <= '{default: '0};
      vol_sh <= '{default: '0};
      cs_q   <= 2'b11;
      sck_q  <= 1'b1;
      sdo_q  <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      err_q <= bad;
      if (go) begin
        st   <= S_SEL;
        job  <= go_job;
        cnt  <= cfg_phase;
        bitn <= '0;
        sh   <= {DEV_ID, 1'b1, go_addr, go_data};
        chip <= go_chip;
        cs_q <= go_chip ? 2'b01 : 2'b10;
        if (ready && go_job == J_RATE) mode   <= m_in;
        if (ready && go_job == J_MUTE) mute_q <= mute_on;
        if (go_addr == FMT_REG) fmt_sh[go_chip] <= go_data;
        if (go_addr == VOL_REG) vol_sh[go_chip] <= go_data;
      end else if (st != S_IDLE && !done) begin
        cnt <= cnt - 1'b1;
      end else begin
        cnt <= cfg_phase;
        case (st)
          S_SEL: begin
            st    <= S_LOW;
            sck_q <= 1'b0;
          end
          S_LOW: begin
            st    <= S_DAT;
            sdo_q <= sh[FRAME_W-1];
            sh    <= sh << 1;
          end
          S_DAT: begin
            st    <= S_HIGH;
            sck_q <= 1'b1;
          end
          S_HIGH: begin
            if (bitn == LAST_BIT) begin
              st    <= S_REL;
              cs_q  <= 2'b11;
              sdo_q <= 1'b1;
            end else begin
              bitn  <= bitn + 1'b1;
              st    <= S_LOW;
              sck_q <= 1'b0;
            end
          end
          S_REL: begin
            st  <= S_IDLE;
            job <= J_WR;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R2
  sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n != 2'b00);

  // R3
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cs_n == 2'b11 && sck && sdo));

  // R3
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != 2'b11) |-> busy);

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != 2'b11 && $past(cs_n) != 2'b11 && sck && $past(sck)) |-> $stable(sdo));

  // R6
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(wr_valid && ready && wr_chip > 2'd1));

  // R6
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (cs_n == 2'b11 && !busy));
endmodule

// File: tb/sim_codec_ctl_writer.sv
`timescale 1ns/1ps
module sim_codec_ctl_writer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg_phase = 8'd1;
  logic wr_valid = 1'b0;
  logic [1:0] wr_chip = '0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic rate_valid = 1'b0;
  logic [17:0] rate_hz = '0;
  logic mute_valid = 1'b0;
  logic mute_on = 1'b0;
  logic ready, busy, err, sck, sdo;
  logic [1:0] cs_n;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  codec_ctl_writer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_phase(cfg_phase),
    .wr_valid(wr_valid), .wr_chip(wr_chip), .wr_addr(wr_addr), .wr_data(wr_data),
    .rate_valid(rate_valid), .rate_hz(rate_hz),
    .mute_valid(mute_valid), .mute_on(mute_on),
    .ready(ready), .busy(busy), .err(err),
    .cs_n(cs_n), .sck(sck), .sdo(sdo)
  );

  // serial receiver model
  logic [15:0] rx_sh = '0;
  int rx_bits = 0;
  logic [15:0] rx_last [2];
  int rx_nbits [2];
  int rx_cnt [2];
  int last_chip = -1;
  int overlap = 0;
  realtime t_fall = 0, t_rise = 0;
  realtime low_w = 0, high_w = 0;

  always @(posedge sck) if (cs_n != 2'b11) begin
    rx_sh = {rx_sh[14:0], sdo};
    rx_bits++;
    low_w = $realtime - t_fall;
    t_rise = $realtime;
  end
  always @(negedge sck) if (cs_n != 2'b11) begin
    if (rx_bits > 0) high_w = $realtime - t_rise;
    t_fall = $realtime;
  end
  always @(negedge cs_n[0] or negedge cs_n[1]) rx_bits = 0;
  always @(cs_n) if (cs_n == 2'b00) overlap++;
  always @(posedge cs_n[0]) begin
    rx_last[0] = rx_sh; rx_nbits[0] = rx_bits; rx_cnt[0]++; last_chip = 0;
  end
  always @(posedge cs_n[1]) begin
    rx_last[1] = rx_sh; rx_nbits[1] = rx_bits; rx_cnt[1]++; last_chip = 1;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] c, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_chip = c; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    wait_idle();
  endtask

  task automatic do_rate(input logic [17:0] r);
    @(negedge clk);
    rate_valid = 1'b1; rate_hz = r;
    @(negedge clk);
    rate_valid = 1'b0;
    wait_idle();
  endtask

  task automatic do_mute(input logic m);
    @(negedge clk);
    mute_valid = 1'b1; mute_on = m;
    @(negedge clk);
    mute_valid = 1'b0;
    wait_idle();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rx_cnt[0] = 0; rx_cnt[1] = 0; overlap = 0;
    @(negedge clk);
    chk("R3 reset ready", ready, 1);
    chk("R3 reset busy", busy, 0);
    chk("R3 reset cs_n", cs_n, 2'b11);
    chk("R3 reset sck/sdo", {sck, sdo}, 2'b11);
    chk("R6 reset err", err, 0);
  endtask

  task automatic t_direct();
    int c0, c1;
    c0 = rx_cnt[0]; c1 = rx_cnt[1];
    @(negedge clk);
    wr_valid = 1'b1; wr_chip = 2'd0; wr_addr = 5'h02; wr_data = 8'hF0;
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R3 busy after accept", busy, 1);
    chk("R3 ready low when busy", ready, 0);
    wait_idle();
    chk("R1 chip0 frame", rx_last[0], 16'hA2F0);
    chk("R1 chip0 bit count", rx_nbits[0], 16);
    chk("R2 chip1 untouched", rx_cnt[1], c1);
    chk("R2 chip0 one frame", rx_cnt[0], c0 + 1);
    chk("R3 lines high after", {cs_n, sck, sdo}, 4'b1111);
    do_write(2'd1, 5'h15, 8'h5A);
    chk("R1 chip1 frame", rx_last[1], 16'hB55A);
    chk("R2 chip0 untouched", rx_cnt[0], c0 + 1);
  endtask

  task automatic t_rate(input logic [17:0] r, input logic [7:0] d0, input logic [7:0] d1, input string tag);
    int c0, c1;
    c0 = rx_cnt[0]; c1 = rx_cnt[1];
    do_rate(r);
    chk({"R7 chip0 ", tag}, rx_last[0], {8'hA2, d0});
    chk({"R7 chip1 ", tag}, rx_last[1], {8'hA2, d1});
    chk({"R7 counts ", tag}, (rx_cnt[0] - c0) * 10 + (rx_cnt[1] - c1), 11);
    chk({"R7 order ", tag}, last_chip, 1);
  endtask

  task automatic t_zero_rate();
    int c0, c1;
    c0 = rx_cnt[0]; c1 = rx_cnt[1];
    @(negedge clk);
    rate_valid = 1'b1; rate_hz = '0;
    @(negedge clk);
    rate_valid = 1'b0;
    chk("R8 zero rate not busy", busy, 0);
    repeat (20) @(negedge clk);
    chk("R8 zero rate no frames", rx_cnt[0] + rx_cnt[1], c0 + c1);
  endtask

  task automatic t_mute();
    do_write(2'd1, 5'h03, 8'h3C);
    chk("R10 direct vol write", rx_last[1], 16'hA33C);
    do_mute(1'b1);
    chk("R9 mute chip0", rx_last[0], 16'hA380);
    chk("R9 mute chip1 keeps low bits", rx_last[1], 16'hA3BC);
    chk("R9 order", last_chip, 1);
    do_mute(1'b0);
    chk("R9 unmute chip0", rx_last[0], 16'hA300);
    chk("R9 unmute chip1", rx_last[1], 16'hA33C);
  endtask

  task automatic t_priority();
    int c0, c1;
    c0 = rx_cnt[0]; c1 = rx_cnt[1];
    @(negedge clk);
    rate_valid = 1'b1; rate_hz = 18'd96000; mute_valid = 1'b1; mute_on = 1'b1;
    @(negedge clk);
    rate_valid = 1'b0; mute_valid = 1'b0;
    wait_idle();
    chk("R11 rate beats mute chip0", rx_last[0], 16'hA2F5);
    chk("R11 rate beats mute count", rx_cnt[0] + rx_cnt[1], c0 + c1 + 2);
    @(negedge clk);
    wr_valid = 1'b1; wr_chip = 2'd0; wr_addr = 5'h07; wr_data = 8'h11;
    mute_valid = 1'b1; mute_on = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; mute_valid = 1'b0;
    wait_idle();
    chk("R11 write beats mute frame", rx_last[0], 16'hA711);
    chk("R11 write beats mute count", rx_cnt[0] + rx_cnt[1], c0 + c1 + 3);
    do_mute(1'b0);
    chk("R11 mute dropped earlier", rx_last[1], 16'hA33C);
  endtask

  task automatic t_bad_chip();
    int c0, c1;
    c0 = rx_cnt[0]; c1 = rx_cnt[1];
    @(negedge clk);
    wr_valid = 1'b1; wr_chip = 2'd2; wr_addr = 5'h02; wr_data = 8'hFF;
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R6 err pulse", err, 1);
    chk("R6 no busy", busy, 0);
    @(negedge clk);
    chk("R6 err one cycle", err, 0);
    repeat (10) @(negedge clk);
    chk("R6 no frames", rx_cnt[0] + rx_cnt[1], c0 + c1);
    chk("R6 port quiet", {cs_n, sck, sdo}, 4'b1111);
  endtask

  task automatic t_timing();
    cfg_phase = 8'd3;
    do_write(2'd0, 5'h09, 8'h81);
    chk("R5 frame at slow rate", rx_last[0], 16'hA981);
    chk("R5 clock low width ns", longint'(low_w), 160);
    chk("R5 clock high width ns", longint'(high_w), 80);
    cfg_phase = 8'd1;
  endtask

  initial begin
    #(20ns * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_direct();
    t_rate(18'd96000,  8'hF5, 8'h05, "96k");
    t_rate(18'd192000, 8'hFA, 8'h0A, "192k");
    t_rate(18'd108000, 8'hF5, 8'h05, "108k edge");
    t_rate(18'd54000,  8'hF0, 8'h00, "54k edge");
    t_rate(18'd44100,  8'hF0, 8'h00, "44k1");
    t_zero_rate();
    t_mute();
    t_priority();
    t_bad_chip();
    t_timing();
    chk("R2 selects never overlapped", overlap, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule